// File: doc/BRIEF.md
# Priority-Ordered Pending Source Resolver

This block takes a table of programmable priority slots and the per-source pending, enable and class-routing vectors. It reports the highest-priority active source for each of two interrupt classes: a fast class and a normal class. The slot index sets the priority, and slot 0 ranks highest. Each slot names any source by its ID, so software can arrange sources in any order it likes. The block is purely combinational, and its result is a packed 32-bit status word.

Each slot is a 32-bit word. Only two parts of the word are decoded: a valid flag and a 6-bit source ID. A slot takes part only if it is valid and its ID names an existing source. The surrounding controller core holds the slot table and the vectors, provides bus access, and drives the processor request lines. This resolver only answers the question "which source wins in each class".

Top module: `pri_res_top`

## Requirements
- R1: A slot word is decoded only through bit 31 (valid) and bits 5:0 (source ID). Bits 30:6 have no effect on the status word.
- R2: A slot with its valid bit clear, or with a source ID of 40 or more, never produces a winner.
- R3: A slot matches when its source is both pending and enabled. The routing bit of that source picks the class: 1 selects fast, 0 selects normal.
- R4: When several slots match the same class, the one with the lowest slot index wins. This holds up to and including slot 39.
- R5: A class with no winner reports its default half, 0x003F. When neither class has a winner, the whole word is 0x003F003F.
- R6: A fast winner sets the status word's low half to 1 in bit 15, the winner's source ID in bits 5:0, and 0 in bits 14:6.
- R7: A normal winner sets the status word's high half to 1 in bit 31, the winner's source ID in bits 21:16, and 0 in bits 30:22.
- R8: The two classes are resolved independently. Each half depends only on the slots that match its own class.
- R9: The same source ID may appear in several slots. The ID reported is always the one held by the earliest matching slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_cfg_i | input | 40*32 | Slot table, flattened; slot k occupies bits 32k+31:32k |
| pend_i | input | 40 | Pending flag per source |
| en_i | input | 40 | Enable flag per source |
| route_i | input | 40 | Class routing per source (1 = fast, 0 = normal) |
| status_o | output | 32 | Packed winner word: normal half on top, fast half below |

## Verification
The checker watches only the status word, so its properties hold for any input values at all. They cover the default pattern of an idle half, the zero padding of an active half, and the rule that a reported ID is always below the source count. Because the block is combinational, the checker assumes the status word has settled whenever its process wakes. The bench changes inputs only between clock edges and samples a few nanoseconds later. The random stimulus draws source IDs from the full 6-bit range, which produces out-of-range IDs and repeated IDs across slots. It also draws junk into the undecoded slot bits and toggles valid flags, so every input case the assertions consider is reached.

// File: rtl/pri_res_pkg.sv
package pri_res_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_W    = 16;
    localparam int ID_W      = 6;
    localparam int VALID_BIT = 31;
    localparam int ID_SPAN   = 1 << ID_W;
    localparam logic [ID_W-1:0] NO_ID = '1;

    typedef enum logic {
        CLS_FAST = 1'b0,
        CLS_NORM = 1'b1
    } cls_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } slot_t;

    function automatic slot_t decode_slot(input logic [WORD_W-1:0] w);
        slot_t s;
        s.valid = w[VALID_BIT];
        s.id    = w[ID_W-1:0];
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] pack_half(input logic found,
                                                    input logic [ID_W-1:0] id);
        logic [HALF_W-1:0] h;
        if (found) h = {1'b1, {(HALF_W-1-ID_W){1'b0}}, id};
        else       h = {{(HALF_W-ID_W){1'b0}}, NO_ID};
        return h;
    endfunction

endpackage

// File: rtl/pri_res_slot_qual.sv
module pri_res_slot_qual
    import pri_res_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [WORD_W-1:0]  word_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] route_i,
    output logic               hit_fast_o,
    output logic               hit_norm_o,
    output logic [ID_W-1:0]    id_o
);
    slot_t            slot;
    logic [ID_SPAN-1:0] pend_ext, en_ext, route_ext;
    logic             in_range;
    logic             active;
    logic             unused_bits;

    assign slot        = decode_slot(word_i);
    assign unused_bits = ^word_i[VALID_BIT-1:ID_W];
    assign pend_ext    = ID_SPAN'(pend_i);
    assign en_ext      = ID_SPAN'(en_i);
    assign route_ext   = ID_SPAN'(route_i);

    always_comb begin
        in_range   = ({1'b0, slot.id} < (ID_W+1)'(NUM_SRC));
        active     = slot.valid && in_range && pend_ext[slot.id] && en_ext[slot.id];
        hit_fast_o = active && route_ext[slot.id];
        hit_norm_o = active && !route_ext[slot.id];
        id_o       = slot.id;
    end

endmodule

// File: rtl/pri_res_pick.sv
module pri_res_pick #(
    parameter int N     = 40,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pri_res_top.sv
module pri_res_top
    import pri_res_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRC   = 40
) (
    input  logic [NUM_SLOTS*WORD_W-1:0] slot_cfg_i,
    input  logic [NUM_SRC-1:0]          pend_i,
    input  logic [NUM_SRC-1:0]          en_i,
    input  logic [NUM_SRC-1:0]          route_i,
    output logic [WORD_W-1:0]           status_o
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int NUM_CLS = 2;

    logic [NUM_SLOTS-1:0] hit [NUM_CLS];
    logic [ID_W-1:0]      slot_id [NUM_SLOTS];
    logic                 found [NUM_CLS];
    logic [IDX_W-1:0]     win_idx [NUM_CLS];
    logic [ID_W-1:0]      win_id [NUM_CLS];
    logic [HALF_W-1:0]    half [NUM_CLS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        pri_res_slot_qual #(.NUM_SRC(NUM_SRC)) u_qual (
            .word_i    (slot_cfg_i[k*WORD_W +: WORD_W]),
            .pend_i    (pend_i),
            .en_i      (en_i),
            .route_i   (route_i),
            .hit_fast_o(hit[CLS_FAST][k]),
            .hit_norm_o(hit[CLS_NORM][k]),
            .id_o      (slot_id[k])
        );
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        pri_res_pick #(.N(NUM_SLOTS)) u_pick (
            .req_i  (hit[c]),
            .found_o(found[c]),
            .idx_o  (win_idx[c])
        );
        assign win_id[c] = slot_id[win_idx[c]];
        assign half[c]   = pack_half(found[c], win_id[c]);
    end

    assign status_o = {half[CLS_NORM], half[CLS_FAST]};

endmodule

// File: rtl/pri_res_chk.sv
module pri_res_chk
    import pri_res_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input logic [WORD_W-1:0] status_i
);
    always_comb begin
        if (!$isunknown(status_i)) begin
            // R5: idle fast half carries the default pattern
            assert_fast_idle_R5: assert (status_i[15] || status_i[15:0] == 16'h003F)
                else $error("fast half idle pattern wrong");
            // R5: idle normal half carries the default pattern
            assert_norm_idle_R5: assert (status_i[31] || status_i[31:16] == 16'h003F)
                else $error("normal half idle pattern wrong");
            // R6: active fast half padded with zeros, ID in range
            assert_fast_pad_R6: assert (!status_i[15] ||
                    (status_i[14:6] == '0 && {1'b0, status_i[5:0]} < 7'(NUM_SRC)))
                else $error("fast half padding or ID wrong");
            // R7: active normal half padded with zeros, ID in range
            assert_norm_pad_R7: assert (!status_i[31] ||
                    (status_i[30:22] == '0 && {1'b0, status_i[21:16]} < 7'(NUM_SRC)))
                else $error("normal half padding or ID wrong");
        end
    end
endmodule

bind pri_res_top pri_res_chk #(.NUM_SRC(NUM_SRC)) u_chk (.status_i(status_o));

// File: tb/pri_res_top_tb.sv
module pri_res_top_tb;
    localparam int NS = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NS*32-1:0] cfg;
    logic [NS-1:0]    pend, en, route;
    logic [31:0]      status;
    logic [31:0]      slots [NS];

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    pri_res_top u_dut (
        .slot_cfg_i(cfg), .pend_i(pend), .en_i(en), .route_i(route), .status_o(status)
    );

    function automatic logic [31:0] ref_word();
        bit f_ok = 0, n_ok = 0;
        int f_id = 0, n_id = 0;
        logic [15:0] lo, hi;
        for (int s = 0; s < NS; s++) begin
            int id = int'(slots[s][5:0]);
            if (slots[s][31] && id < NS && pend[id] && en[id]) begin
                if (route[id] && !f_ok) begin f_ok = 1; f_id = id; end
                if (!route[id] && !n_ok) begin n_ok = 1; n_id = id; end
            end
        end
        lo = f_ok ? (16'h8000 + 16'(f_id)) : 16'h003F;
        hi = n_ok ? (16'h8000 + 16'(n_id)) : 16'h003F;
        return {hi, lo};
    endfunction

    task automatic clear_all();
        for (int s = 0; s < NS; s++) slots[s] = '0;
        pend = '0; en = '0; route = '0;
    endtask

    task automatic apply_and_check(input string req, input logic [31:0] exp);
        @(negedge clk);
        for (int s = 0; s < NS; s++) cfg[s*32 +: 32] = slots[s];
        #2;
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, status, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_all();
        cfg = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R5: nothing configured
        apply_and_check("R5 reset", 32'h003F003F);

        // R3/R7: normal-class single winner
        slots[5] = 32'h8000_0003; pend[3] = 1; en[3] = 1;
        apply_and_check("R3 R7 normal", 32'h8003_003F);
        // R6: route to fast
        route[3] = 1;
        apply_and_check("R6 fast", 32'h003F_8003);
        // R3: not enabled
        en[3] = 0;
        apply_and_check("R3 disabled", 32'h003F003F);
        en[3] = 1; pend[3] = 0;
        apply_and_check("R3 not pending", 32'h003F003F);
        pend[3] = 1;
        // R2: invalid slot
        slots[5] = 32'h0000_0003;
        apply_and_check("R2 invalid", 32'h003F003F);
        // R2: out-of-range id
        clear_all();
        slots[0] = 32'h8000_002D; pend = '1; en = '1;
        apply_and_check("R2 range", 32'h003F003F);
        // R1: junk in undecoded bits
        clear_all();
        slots[7] = 32'hFFFF_FFC9; pend[9] = 1; en[9] = 1;
        apply_and_check("R1 junk bits", 32'h8009_003F);
        // R4: lower slot wins
        clear_all();
        slots[2] = 32'h8000_0007; slots[9] = 32'h8000_0001;
        pend = '1; en = '1;
        apply_and_check("R4 lowest slot", 32'h8007_003F);
        // R4: last slot reachable
        clear_all();
        slots[39] = 32'h8000_0027; pend[39] = 1; en[39] = 1; route[39] = 1;
        apply_and_check("R4 slot 39", 32'h003F_8027);
        // R8: both classes at once
        clear_all();
        slots[0] = 32'h8000_000A; slots[1] = 32'h8000_0014;
        pend = '1; en = '1; route[10] = 1;
        apply_and_check("R8 both", 32'h8014_800A);
        // R9: duplicate ids
        clear_all();
        slots[1] = 32'h8000_0004; slots[3] = 32'h8000_0004; slots[4] = 32'h8000_0002;
        pend = '1; en = '1;
        apply_and_check("R9 duplicate", 32'h8004_003F);

        // Random sweep, R1-covering reference across all rules
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < NS; s++) begin
                slots[s] = $urandom;
                slots[s][31] = ($urandom_range(0, 3) != 0);
                slots[s][5:0] = 6'($urandom_range(0, 63));
            end
            pend  = {$urandom, $urandom} & {$urandom, $urandom};
            en    = {$urandom, $urandom};
            route = {$urandom, $urandom};
            if (n % 4 == 0) pend = pend & {$urandom, $urandom};
            apply_and_check("R4 R9 random", ref_word());
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule